// File: doc/BRIEF.md
# SONET Transmit Path Overhead Generator

This block sits in the transmit direction of an STS-1 path and writes the nine path overhead bytes into an outgoing synchronous payload envelope. Payload bytes arrive on a valid/ready byte stream. Each byte comes with its row (0 to 8) and its column inside the envelope. Column 0 is the overhead column. In that column the block swaps the incoming byte for the overhead byte that belongs to the row: path trace, parity, signal label, status, user channel, multiframe indicator and the three growth bytes. It forwards every other byte untouched.

The parity byte carries an even-parity BIP-8 over everything sent in the previous envelope. A one-shot request can corrupt it for test purposes. The status byte reports remote defects and remote errors. It follows defect levels and a stream of error counts from the receive side, and software can force either indication. The path trace byte cycles through a message buffer of 1, 16 or 64 entries. Software can also force the whole envelope to all ones, which signals an alarm downstream.

The stream interface adds no storage. `m_valid` equals `s_valid` and `s_ready` equals `m_ready`, so back-pressure from the consumer reaches the producer in the same cycle. A byte is transferred on a rising edge where `s_valid` and `m_ready` are both high. While a stall lasts, the producer must hold the byte and its position stable. The producer must present positions in order, starting from row 0, column 0.

Top module: `sonet_tx_poh`

## Requirements
- R1: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in every cycle. A byte outside column 0 leaves on `m_data` unchanged unless the alarm fill of R9 is active.
- R2: The byte sent in row 1 of column 0 is the even-parity BIP-8: the XOR of all bytes transferred on `m_data` during the previous envelope, whose last byte is at row 8, column COLS-1. In the first envelope after reset it is 8'h00.
- R3: A one-cycle pulse on `sw_b3_err` inverts all eight bits of the next parity byte sent, and only that one. The request then clears itself.
- R4: Status byte (row 3) bit 3 is the remote defect indication. It is 1 while any bit of `rx_path_defects` is set, while `rx_lcd` is set, or while `sw_rdi` is set. Otherwise it is 0. Bits 2..0 are always 0.
- R5: Each transfer with `rx_bip_valid` high adds `rx_bip_count` to a pending error count that saturates at 8. A value above 8 adds 0. The pending count goes out in status byte bits 7..4 and returns to 0 once the status byte has been transferred.
- R6: While `sw_rei` is high and the pending count is 0, status bits 7..4 read 1. A nonzero pending count is sent as it is.
- R7: Row 0 carries trace buffer entry `ptr`. `trace_len` selects the message length: 0 gives 1 entry, 1 gives 16 entries, 2 or 3 give TRACE_DEPTH entries. `ptr` starts at 0 after reset and steps by one after each trace byte, wrapping to 0 after the last entry. `trace_we` writes `trace_wdata` to entry `trace_addr`.
- R8: Rows 2, 4, 5, 6, 7 and 8 of column 0 carry `c2_val`, `f2_val`, `h4_val`, `z3_val`, `z4_val` and `z5_val`.
- R9: While `sw_ais` is high, every byte sent, overhead included, is 8'hFF. Parity, trace pointer, injection request and pending count advance as in R2, R3, R5 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input envelope byte |
| s_row | input | 4 | Row of the input byte, 0..8 |
| s_col | input | $clog2(COLS) | Column of the input byte, 0 is overhead |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Consumer ready |
| m_data | output | 8 | Output envelope byte |
| rx_path_defects | input | 5 | Receive path defect levels |
| rx_lcd | input | 1 | Loss of cell delineation level |
| rx_bip_valid | input | 1 | Strobe for rx_bip_count |
| rx_bip_count | input | 4 | Receive parity error count |
| sw_rdi | input | 1 | Force remote defect indication |
| sw_rei | input | 1 | Force remote error indication |
| sw_ais | input | 1 | Force all-ones alarm fill |
| sw_b3_err | input | 1 | Pulse: corrupt next parity byte |
| trace_we | input | 1 | Trace buffer write enable |
| trace_addr | input | $clog2(TRACE_DEPTH) | Trace buffer write address |
| trace_wdata | input | 8 | Trace buffer write data |
| trace_len | input | 2 | Trace length select |
| c2_val | input | 8 | Signal label byte |
| f2_val | input | 8 | User channel byte |
| h4_val | input | 8 | Multiframe indicator byte |
| z3_val | input | 8 | Growth byte, row 6 |
| z4_val | input | 8 | Growth byte, row 7 |
| z5_val | input | 8 | Growth byte, row 8 |

## Verification
The bench builds the block with COLS = 3, so an envelope is 27 bytes long. That makes it cheap to run about ninety envelopes and to compare every byte against an arithmetic model. TRACE_DEPTH stays at 64, so the 1-, 16- and 64-entry trace lengths each run past at least one full wrap. Across envelopes the bench rotates through each defect source alone, count values on both sides of the saturation point, forced indications, parity corruption and alarm fill, with consumer stalls mixed in.

// File: rtl/poh_tx_pkg.sv
package poh_tx_pkg;
  localparam int POH_ROWS = 9;
  localparam int REI_MAX  = 8;

  typedef enum logic [3:0] {
    ROW_TRACE = 4'd0,
    ROW_PAR   = 4'd1,
    ROW_LABEL = 4'd2,
    ROW_STAT  = 4'd3,
    ROW_USER  = 4'd4,
    ROW_MFI   = 4'd5,
    ROW_GR3   = 4'd6,
    ROW_GR4   = 4'd7,
    ROW_GR5   = 4'd8
  } poh_row_e;

  function automatic logic [3:0] rei_clip(input logic [3:0] v);
    return (v > 4'(REI_MAX)) ? 4'd0 : v;
  endfunction
endpackage

// File: rtl/poh_bip.sv
module poh_bip (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       last,
  input  logic       is_par,
  input  logic [7:0] obyte,
  input  logic       inj_req,
  output logic [7:0] par_byte
);
  logic [7:0] acc;
  logic [7:0] par_q;
  logic       inj_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      par_q    <= '0;
      inj_pend <= 1'b0;
    end else begin
      if (fire) begin
        if (last) begin
          acc   <= '0;
          par_q <= acc ^ obyte;
        end else begin
          acc <= acc ^ obyte;
        end
      end
      if (fire && is_par) inj_pend <= inj_req;
      else if (inj_req)   inj_pend <= 1'b1;
    end
  end

  assign par_byte = par_q ^ {8{inj_pend}};

  assert_inj_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_par && !inj_req) |=> !inj_pend);
  assert_acc_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> (acc == 8'h00));
endmodule

// File: rtl/poh_status.sv
module poh_status
  import poh_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_valid,
  input  logic [3:0] cnt_in,
  input  logic       rei_force,
  input  logic [4:0] path_def,
  input  logic       lcd,
  input  logic       rdi_force,
  input  logic       stat_fire,
  output logic [7:0] stat_byte
);
  logic [3:0] pend;
  logic [3:0] base;
  logic [4:0] sum;
  logic [3:0] rei_field;
  logic       rdi;

  assign base = stat_fire ? 4'd0 : pend;
  assign sum  = {1'b0, base} + {1'b0, rei_clip(cnt_in)};

  always_ff @(posedge clk) begin
    if (!rst_n)         pend <= '0;
    else if (cnt_valid) pend <= (sum > 5'(REI_MAX)) ? 4'(REI_MAX) : sum[3:0];
    else if (stat_fire) pend <= '0;
  end

  assign rei_field = (pend != 4'd0) ? pend : (rei_force ? 4'd1 : 4'd0);
  assign rdi       = (|path_def) | lcd | rdi_force;
  assign stat_byte = {rei_field, rdi, 3'b000};

  assert_rei_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= 4'(REI_MAX));
  assert_rdi_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|path_def) |-> stat_byte[3]);
endmodule

// File: rtl/poh_trace.sv
module poh_trace #(
  parameter int DEPTH = 64,
  parameter int MID   = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [1:0]    len_sel,
  input  logic          tr_fire,
  output logic [7:0]    tr_byte
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [AW:0]   len;

  always_comb begin
    unique case (len_sel)
      2'd0:    len = (AW+1)'(1);
      2'd1:    len = (AW+1)'(MID);
      default: len = (AW+1)'(DEPTH);
    endcase
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (tr_fire) begin
      if ({1'b0, ptr} >= len - 1'b1) ptr <= '0;
      else                           ptr <= ptr + 1'b1;
    end
  end

  assign tr_byte = mem[ptr];

  assert_trace_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tr_fire |=> ({1'b0, ptr} < $past(len)));
endmodule

// File: rtl/sonet_tx_poh.sv
module sonet_tx_poh
  import poh_tx_pkg::*;
#(
  parameter int COLS        = 87,
  parameter int TRACE_DEPTH = 64,
  localparam int CW  = $clog2(COLS),
  localparam int TAW = $clog2(TRACE_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [7:0]     s_data,
  input  logic [3:0]     s_row,
  input  logic [CW-1:0]  s_col,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [7:0]     m_data,
  input  logic [4:0]     rx_path_defects,
  input  logic           rx_lcd,
  input  logic           rx_bip_valid,
  input  logic [3:0]     rx_bip_count,
  input  logic           sw_rdi,
  input  logic           sw_rei,
  input  logic           sw_ais,
  input  logic           sw_b3_err,
  input  logic           trace_we,
  input  logic [TAW-1:0] trace_addr,
  input  logic [7:0]     trace_wdata,
  input  logic [1:0]     trace_len,
  input  logic [7:0]     c2_val,
  input  logic [7:0]     f2_val,
  input  logic [7:0]     h4_val,
  input  logic [7:0]     z3_val,
  input  logic [7:0]     z4_val,
  input  logic [7:0]     z5_val
);
  logic       fire, is_oh, last;
  logic [7:0] par_byte, stat_byte, tr_byte, oh_byte;

  assign fire    = s_valid && m_ready;
  assign m_valid = s_valid;
  assign s_ready = m_ready;
  assign is_oh   = (s_col == '0);
  assign last    = (s_row == 4'(POH_ROWS - 1)) && (s_col == CW'(COLS - 1));

  poh_bip u_bip (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(last),
    .is_par(is_oh && s_row == ROW_PAR), .obyte(m_data),
    .inj_req(sw_b3_err), .par_byte(par_byte)
  );

  poh_status u_stat (
    .clk(clk), .rst_n(rst_n), .cnt_valid(rx_bip_valid), .cnt_in(rx_bip_count),
    .rei_force(sw_rei), .path_def(rx_path_defects), .lcd(rx_lcd),
    .rdi_force(sw_rdi), .stat_fire(fire && is_oh && s_row == ROW_STAT),
    .stat_byte(stat_byte)
  );

  poh_trace #(.DEPTH(TRACE_DEPTH)) u_trace (
    .clk(clk), .rst_n(rst_n), .we(trace_we), .waddr(trace_addr),
    .wdata(trace_wdata), .len_sel(trace_len),
    .tr_fire(fire && is_oh && s_row == ROW_TRACE), .tr_byte(tr_byte)
  );

  always_comb begin
    unique case (s_row)
      ROW_TRACE: oh_byte = tr_byte;
      ROW_PAR:   oh_byte = par_byte;
      ROW_LABEL: oh_byte = c2_val;
      ROW_STAT:  oh_byte = stat_byte;
      ROW_USER:  oh_byte = f2_val;
      ROW_MFI:   oh_byte = h4_val;
      ROW_GR3:   oh_byte = z3_val;
      ROW_GR4:   oh_byte = z4_val;
      default:   oh_byte = z5_val;
    endcase
  end

  assign m_data = sw_ais ? 8'hFF : (is_oh ? oh_byte : s_data);

  assert_alarm_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && sw_ais) |-> (m_data == 8'hFF));
  assert_payload_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !is_oh && !sw_ais) |-> (m_data == s_data));
  assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !m_ready) |-> (m_valid && !s_ready));
endmodule

// File: tb/sonet_tx_poh_tb.sv
module sonet_tx_poh_tb;
  localparam int COLS = 3;
  localparam int CW   = $clog2(COLS);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, s_valid, s_ready, m_valid, m_ready;
  logic [7:0] s_data, m_data;
  logic [3:0] s_row;
  logic [CW-1:0] s_col;
  logic [4:0] rx_path_defects;
  logic rx_lcd, rx_bip_valid, sw_rdi, sw_rei, sw_ais, sw_b3_err, trace_we;
  logic [3:0] rx_bip_count;
  logic [5:0] trace_addr;
  logic [7:0] trace_wdata, c2_val, f2_val, h4_val, z3_val, z4_val, z5_val;
  logic [1:0] trace_len;

  sonet_tx_poh #(.COLS(COLS), .TRACE_DEPTH(64)) u_dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] m_acc, m_par, trbuf [64];
  int m_ptr, m_rei;
  bit m_inj;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int tlen(input logic [1:0] s);
    return (s == 2'd0) ? 1 : ((s == 2'd1) ? 16 : 64);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_acc = 8'h00; m_par = 8'h00; m_ptr = 0; m_rei = 0; m_inj = 0;
  endtask

  task automatic rei_pulse(input logic [3:0] v);
    int a;
    @(negedge clk);
    rx_bip_valid = 1'b1; rx_bip_count = v;
    @(posedge clk);
    #1 rx_bip_valid = 1'b0;
    a = (v > 4'd8) ? 0 : int'(v);
    m_rei = (m_rei + a > 8) ? 8 : m_rei + a;
  endtask

  task automatic send_frame(input int f);
    logic [7:0] exp, st;
    int rf;
    string tag;
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        s_valid = 1'b1; s_row = 4'(r); s_col = CW'(c);
        s_data = 8'((f * 37 + r * 11 + c * 5) ^ 8'h5A);
        if (((f + r + c) % 7) == 0) begin
          m_ready = 1'b0;
          #2;
          chk("R1 stall valid", {7'b0, m_valid}, 8'd1);
          chk("R1 stall ready", {7'b0, s_ready}, 8'd0);
          @(negedge clk);
          m_ready = 1'b1;
        end
        rf = (m_rei != 0) ? m_rei : (sw_rei ? 1 : 0);
        st = {4'(rf), (|rx_path_defects) | rx_lcd | sw_rdi, 3'b000};
        tag = "R1 payload";
        exp = s_data;
        if (c == 0) begin
          case (r)
            0: begin exp = trbuf[m_ptr]; tag = "R7 trace"; end
            1: begin exp = m_par ^ {8{m_inj}}; tag = m_inj ? "R3 inject" : "R2 parity"; end
            2: begin exp = c2_val; tag = "R8 label"; end
            3: begin exp = st; tag = "R4 R5 R6 status"; end
            4: begin exp = f2_val; tag = "R8 user"; end
            5: begin exp = h4_val; tag = "R8 mfi"; end
            6: begin exp = z3_val; tag = "R8 growth3"; end
            7: begin exp = z4_val; tag = "R8 growth4"; end
            default: begin exp = z5_val; tag = "R8 growth5"; end
          endcase
        end
        if (sw_ais) begin exp = 8'hFF; tag = "R9 alarm"; end
        #2;
        chk(tag, m_data, exp);
        chk("R1 ready", {7'b0, s_ready}, 8'd1);
        @(posedge clk);
        if (c == 0 && r == 0) m_ptr = (m_ptr >= tlen(trace_len) - 1) ? 0 : m_ptr + 1;
        if (c == 0 && r == 1) m_inj = 0;
        if (c == 0 && r == 3) m_rei = 0;
        if (r == 8 && c == COLS - 1) begin m_par = m_acc ^ exp; m_acc = 8'h00; end
        else m_acc = m_acc ^ exp;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic run_mode(input logic [1:0] sel, input int frames);
    do_reset();
    trace_len = sel;
    #2;
    chk("R1 reset idle valid", {7'b0, m_valid}, 8'd0);
    for (int f = 0; f < frames; f++) begin
      @(negedge clk);
      rx_path_defects = ((f % 8) < 5) ? 5'(1 << (f % 8)) : 5'd0;
      rx_lcd = ((f % 8) == 5);
      sw_rdi = ((f % 8) == 6);
      sw_rei = ((f % 5) == 0);
      sw_ais = ((f % 9) == 8);
      c2_val = 8'(f + 8'h13); f2_val = 8'(f * 3); h4_val = 8'(8'hC0 + f);
      z3_val = 8'(f ^ 8'h33); z4_val = 8'(f ^ 8'h44); z5_val = 8'(f ^ 8'h55);
      if ((f % 3) != 2) rei_pulse(4'(f % 11));
      if ((f % 6) == 3) rei_pulse(4'd7);
      if ((f % 4) == 1) begin
        @(negedge clk);
        sw_b3_err = 1'b1;
        @(posedge clk);
        #1 sw_b3_err = 1'b0;
        m_inj = 1;
      end
      send_frame(f);
    end
  endtask

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b1; s_data = '0; s_row = '0; s_col = '0;
    rx_path_defects = '0; rx_lcd = 0; rx_bip_valid = 0; rx_bip_count = '0;
    sw_rdi = 0; sw_rei = 0; sw_ais = 0; sw_b3_err = 0; trace_we = 0;
    trace_addr = '0; trace_wdata = '0; trace_len = 2'd2;
    c2_val = '0; f2_val = '0; h4_val = '0; z3_val = '0; z4_val = '0; z5_val = '0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      trace_we = 1'b1; trace_addr = 6'(i);
      trace_wdata = 8'(8'hA0 ^ (i * 3));
      trbuf[i] = 8'(8'hA0 ^ (i * 3));
    end
    @(negedge clk);
    trace_we = 1'b0;
    run_mode(2'd0, 3);
    run_mode(2'd1, 18);
    run_mode(2'd2, 66);
    run_mode(2'd3, 2);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule